// File: doc/BRIEF.md
# Descriptor Ring Writeback Engine

This block moves completed descriptors from a local cache back into a ring held in host memory. When asked, it works out how many used cache entries may go back in a single DMA write burst and waits a programmable number of cycles. It then issues the write, and once the write completes it pops those entries from the used queue and advances the ring head. Only one burst is in flight at a time. A request that arrives during a burst is merged into a follow-on burst when its alignment mask is smaller than the stored one, and is dropped otherwise.

The burst is trimmed so that it ends on an alignment boundary chosen by the mask. A burst that would cross the end of the ring stops at the last slot. The remainder then goes out in an automatic follow-on burst that starts from slot zero. Two interrupt-delay timers sit beside the engine: a per-packet timer that restarts on every packet event, and an absolute timer that runs from the first event. When either timer expires, the engine is forced into an unmasked writeback and an interrupt is posted.

Top module: `desc_wb_engine`

## Requirements
- R1: After reset, `busy`, `dmaReq`, `popValid` and `irqPost` are 0 and `headOut` is 0.
- R2: If an idle request has `usedCount + head < ringLen` and a zero mask, the burst count equals `usedCount`. `dmaAddr` is `ringBase + head*16` and `dmaLen` is `count*16`, with 16 bytes per descriptor.
- R3: If an idle request has `usedCount + head < ringLen` and a nonzero mask, the count is `usedCount & ~mask`.
- R4: If `usedCount + head >= ringLen`, the count is `ringLen - head` and the mask is not applied. After completion, a follow-on burst from slot 0 is evaluated with the stored mask and the refreshed `usedCount`.
- R5: A request whose computed count is zero produces no DMA request, and `busy` stays 0.
- R6: With `wbDelay = D` and `draining` low, a request presented in cycle k raises `dmaReq` for exactly one cycle in cycle k+D+2. While `draining` is high, the issue is held back, and `dmaReq` rises in the cycle after `draining` falls.
- R7: Only one burst is in flight. A request made during a burst whose mask is not smaller than the stored mask has no effect: no follow-on burst occurs.
- R8: A request made during a burst whose mask is smaller than the stored mask causes a follow-on burst after completion. That burst uses the smaller mask.
- R9: The cycle after a cycle with `dmaDone` high in the waiting state, `popValid` pulses for one cycle and `popCnt` equals the burst count. `headOut` then equals `(head + count) mod ringLen`.
- R10: `busy` is high from the cycle after acceptance through the cycle after `dmaDone`, and low the cycle after that.
- R11: The per-packet timer reloads `pktDelay` on every `pktEvt`. The absolute timer loads `absDelay` only when it is idle. A delay of 0 disables a timer. An event in cycle k with delay T expires in cycle k+T. The expiry acts as a request with mask 0 in that cycle, and `irqPost` pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbReq | input | 1 | Writeback request strobe |
| wbMask | input | 16 | Alignment mask for the request |
| ringBase | input | 32 | Byte address of ring slot 0 |
| ringLen | input | 16 | Ring length in descriptors |
| usedCount | input | 16 | Completed entries waiting in the cache |
| wbDelay | input | 8 | Cycles from acceptance to issue |
| draining | input | 1 | Holds back DMA issue while high |
| dmaReq | output | 1 | One-cycle DMA write request |
| dmaAddr | output | 32 | DMA write byte address |
| dmaLen | output | 20 | DMA write byte length |
| dmaDone | input | 1 | DMA write completion strobe |
| popValid | output | 1 | Pop strobe for the used queue |
| popCnt | output | 16 | Entries to pop |
| headOut | output | 16 | Current ring head index |
| busy | output | 1 | Writeback in progress |
| pktEvt | input | 1 | Packet event for the delay timers |
| pktDelay | input | 16 | Per-packet timer reload value |
| absDelay | input | 16 | Absolute timer load value |
| irqPost | output | 1 | Interrupt post pulse after a timer expiry |

## Verification
A stale stored mask or a pending flag that is never cleared shows up at the ports as a missing or extra follow-on `dmaReq`. That happens within wbDelay+4 cycles of `popValid`, so each burst is followed until `busy` falls, and the absence of a further request is confirmed. A wrong head register shows up as a bad `dmaAddr` on the very next burst and as a wrong `headOut` one cycle after completion. A slip in the delay counter or the drain hold moves the `dmaReq` pulse by a cycle, which the bench samples cycle by cycle.

// File: rtl/wbe_pkg.sv
package wbe_pkg;
  typedef struct packed {
    logic load;     // latch count, address and length of a new burst
    logic advance;  // burst completed: move head, publish pop count
  } wbe_strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_WAIT, ST_POST} wbe_state_t;
endpackage

// File: rtl/wbe_timer.sv
module wbe_timer #(
  parameter int TMR_W   = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pktEvt,
  input  logic [TMR_W-1:0] delay,
  output logic             expire
);
  logic             runQ;
  logic [TMR_W-1:0] cntQ;
  logic             loadNow;

  assign loadNow = pktEvt && (RESTART || !runQ) && (delay != '0);
  assign expire  = runQ && (cntQ == TMR_W'(1)) && !(RESTART && pktEvt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
      cntQ <= '0;
    end else if (loadNow) begin
      runQ <= 1'b1;
      cntQ <= delay;
    end else if (runQ) begin
      if (cntQ == TMR_W'(1)) runQ <= 1'b0;
      else                   cntQ <= cntQ - 1'b1;
    end
  end

  AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    expire && !pktEvt |=> !expire); // R11
endmodule

// File: rtl/wbe_dpath.sv
module wbe_dpath
  import wbe_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16,
  localparam int SHIFT     = $clog2(DESC_BYTES),
  localparam int LEN_W     = IDX_W + SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbe_strobe_t       strb,
  input  logic [IDX_W-1:0]  usedCount,
  input  logic [IDX_W-1:0]  ringLen,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [IDX_W-1:0]  effMask,
  output logic              calcZero,
  output logic              calcClip,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  output logic [IDX_W-1:0]  popCnt,
  output logic [IDX_W-1:0]  headOut
);
  logic [IDX_W-1:0] headQ, cntQ, calcCnt;
  logic [IDX_W:0]   reach, sumHead, wrapHead;

  always_comb begin
    reach    = {1'b0, usedCount} + {1'b0, headQ};
    calcClip = reach >= {1'b0, ringLen};
    calcCnt  = calcClip ? (ringLen - headQ) : (usedCount & ~effMask);
    calcZero = (calcCnt == '0);
    sumHead  = {1'b0, headQ} + {1'b0, cntQ};
    wrapHead = (sumHead >= {1'b0, ringLen}) ? (sumHead - {1'b0, ringLen}) : sumHead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ   <= '0;
      cntQ    <= '0;
      popCnt  <= '0;
      dmaAddr <= '0;
      dmaLen  <= '0;
    end else begin
      if (strb.load) begin
        cntQ    <= calcCnt;
        dmaAddr <= ringBase + (ADDR_W'(headQ) << SHIFT);
        dmaLen  <= LEN_W'(calcCnt) << SHIFT;
      end
      if (strb.advance) begin
        headQ  <= wrapHead[IDX_W-1:0];
        popCnt <= cntQ;
      end
    end
  end

  assign headOut = headQ;

  AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> headOut < ringLen); // R9
  AST_BURST_FITS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> ({1'b0, headOut} + {1'b0, cntQ}) <= {1'b0, ringLen}); // R4
endmodule

// File: rtl/wbe_ctrl.sv
module wbe_ctrl
  import wbe_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wbReq,
  input  logic [IDX_W-1:0] wbMask,
  input  logic             tmrFire,
  input  logic             draining,
  input  logic [DLY_W-1:0] wbDelay,
  input  logic             dmaDone,
  input  logic             calcZero,
  input  logic             calcClip,
  output wbe_strobe_t      strb,
  output logic [IDX_W-1:0] effMask,
  output logic             dmaReq,
  output logic             popValid,
  output logic             busy,
  output logic             irqPost
);
  wbe_state_t       state;
  logic [DLY_W-1:0] dlyQ;
  logic [IDX_W-1:0] storedMask;
  logic             pendMore, redoQ;
  logic             anyReq, mergeHit;

  // Smallest mask among the redo, an external request and a timer expiry
  always_comb begin
    effMask = redoQ ? storedMask : '1;
    if (wbReq && (wbMask < effMask)) effMask = wbMask;
    if (tmrFire) effMask = '0;
    anyReq   = wbReq || tmrFire || redoQ;
    mergeHit = (state != ST_IDLE) && (wbReq || tmrFire) && (effMask < storedMask);
  end

  assign strb.load    = (state == ST_IDLE) && anyReq && !calcZero;
  assign strb.advance = (state == ST_WAIT) && dmaDone;
  assign busy         = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      dlyQ       <= '0;
      storedMask <= '0;
      pendMore   <= 1'b0;
      redoQ      <= 1'b0;
      dmaReq     <= 1'b0;
      popValid   <= 1'b0;
      irqPost    <= 1'b0;
    end else begin
      redoQ    <= 1'b0;
      dmaReq   <= 1'b0;
      popValid <= 1'b0;
      irqPost  <= tmrFire;
      if (mergeHit) begin
        storedMask <= effMask;
        pendMore   <= 1'b1;
      end
      unique case (state)
        ST_IDLE: if (anyReq) begin
          storedMask <= effMask;
          pendMore   <= calcClip;
          if (!calcZero) begin
            state <= ST_DELAY;
            dlyQ  <= wbDelay;
          end
        end
        ST_DELAY: begin
          if (dlyQ != '0) dlyQ <= dlyQ - 1'b1;
          else if (!draining) begin
            state  <= ST_WAIT;
            dmaReq <= 1'b1;
          end
        end
        ST_WAIT: if (dmaDone) begin
          state    <= ST_POST;
          popValid <= 1'b1;
        end
        ST_POST: begin
          state    <= ST_IDLE;
          redoQ    <= pendMore || mergeHit;
          pendMore <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_BURST: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |=> !dmaReq); // R7
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> !$past(draining)); // R6
  AST_BUSY_AT_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> busy); // R10
  AST_POP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> $past(dmaDone)); // R9
  AST_IDLE_NO_DMA: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !dmaReq); // R5
endmodule

// File: rtl/desc_wb_engine.sv
module desc_wb_engine
  import wbe_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16,
  parameter int DLY_W      = 8,
  parameter int TMR_W      = 16,
  localparam int LEN_W     = IDX_W + $clog2(DESC_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbReq,
  input  logic [IDX_W-1:0]  wbMask,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [IDX_W-1:0]  ringLen,
  input  logic [IDX_W-1:0]  usedCount,
  input  logic [DLY_W-1:0]  wbDelay,
  input  logic              draining,
  output logic              dmaReq,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  input  logic              dmaDone,
  output logic              popValid,
  output logic [IDX_W-1:0]  popCnt,
  output logic [IDX_W-1:0]  headOut,
  output logic              busy,
  input  logic              pktEvt,
  input  logic [TMR_W-1:0]  pktDelay,
  input  logic [TMR_W-1:0]  absDelay,
  output logic              irqPost
);
  wbe_strobe_t      strb;
  logic [IDX_W-1:0] effMask;
  logic             calcZero, calcClip, tmrFire;
  logic [1:0]       tmrExp;

  // Timer 0 restarts per packet, timer 1 runs from the first packet
  for (genvar g = 0; g < 2; g++) begin : gTmr
    wbe_timer #(.TMR_W(TMR_W), .RESTART(g == 0)) uTmr (
      .clk    (clk),
      .rstN   (rstN),
      .pktEvt (pktEvt),
      .delay  ((g == 0) ? pktDelay : absDelay),
      .expire (tmrExp[g])
    );
  end
  assign tmrFire = |tmrExp;

  wbe_ctrl #(.IDX_W(IDX_W), .DLY_W(DLY_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wbReq(wbReq), .wbMask(wbMask), .tmrFire(tmrFire),
    .draining(draining), .wbDelay(wbDelay), .dmaDone(dmaDone),
    .calcZero(calcZero), .calcClip(calcClip), .strb(strb), .effMask(effMask),
    .dmaReq(dmaReq), .popValid(popValid), .busy(busy), .irqPost(irqPost)
  );

  wbe_dpath #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .usedCount(usedCount), .ringLen(ringLen),
    .ringBase(ringBase), .effMask(effMask), .calcZero(calcZero), .calcClip(calcClip),
    .dmaAddr(dmaAddr), .dmaLen(dmaLen), .popCnt(popCnt), .headOut(headOut)
  );
endmodule

// File: tb/desc_wb_engine_test.sv
`timescale 1ns/1ps
module desc_wb_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbReq = 1'b0;
  logic [15:0] wbMask = '0;
  logic [31:0] ringBase = 32'h1000_0000;
  logic [15:0] ringLen = 16'd32;
  logic [15:0] usedCount = '0;
  logic [7:0]  wbDelay = 8'd2;
  logic        draining = 1'b0;
  logic        dmaReq;
  logic [31:0] dmaAddr;
  logic [19:0] dmaLen;
  logic        dmaDone = 1'b0;
  logic        popValid;
  logic [15:0] popCnt;
  logic [15:0] headOut;
  logic        busy;
  logic        pktEvt = 1'b0;
  logic [15:0] pktDelay = '0;
  logic [15:0] absDelay = '0;
  logic        irqPost;

  int total = 0;
  int bad = 0;
  int expHead = 0;

  always #5 clk = ~clk;

  desc_wb_engine uut (
    .clk(clk), .rstN(rstN), .wbReq(wbReq), .wbMask(wbMask), .ringBase(ringBase),
    .ringLen(ringLen), .usedCount(usedCount), .wbDelay(wbDelay), .draining(draining),
    .dmaReq(dmaReq), .dmaAddr(dmaAddr), .dmaLen(dmaLen), .dmaDone(dmaDone),
    .popValid(popValid), .popCnt(popCnt), .headOut(headOut), .busy(busy),
    .pktEvt(pktEvt), .pktDelay(pktDelay), .absDelay(absDelay), .irqPost(irqPost)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected burst size from the requirements R2, R3, R4
  function automatic void calcBurst(input int used, input int head, input int len,
                                    input int mask, output int cnt, output bit clip);
    if (used + head >= len) begin
      cnt = len - head;
      clip = 1'b1;
    end else begin
      cnt = used & ~mask;
      clip = 1'b0;
    end
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // Called at the negedge of the cycle in which the request is presented
  task automatic runBurst(input int expCnt, input int hold, input bit inj,
                          input int injA, input int injB, input int refill,
                          input string tag);
    int d;
    d = int'(wbDelay);
    if (hold > 0) draining = 1'b1;
    for (int i = 1; i <= d + 1 + hold; i++) begin
      step();
      if (i == 1) begin
        wbReq = 1'b0;
        check("R10 busy after accept", 64'(busy), 64'd1);
      end
      check("R6 no early dmaReq", 64'(dmaReq), 64'd0);
      if (i == d + 1 + hold) draining = 1'b0;
    end
    step();
    check("R6 dmaReq on time", 64'(dmaReq), 64'd1);
    check({tag, " dmaAddr"}, 64'(dmaAddr), 64'(ringBase + 32'(expHead * 16)));
    check({tag, " dmaLen"}, 64'(dmaLen), 64'(expCnt * 16));
    step();
    if (inj) begin wbReq = 1'b1; wbMask = 16'(injA); end
    step();
    if (inj) wbMask = 16'(injB);
    step();
    wbReq = 1'b0;
    dmaDone = 1'b1;
    step();
    dmaDone = 1'b0;
    expHead = (expHead + expCnt) % int'(ringLen);
    check("R9 popValid", 64'(popValid), 64'd1);
    check("R9 popCnt", 64'(popCnt), 64'(expCnt));
    check("R9 headOut", 64'(headOut), 64'(expHead));
    check("R10 busy through completion", 64'(busy), 64'd1);
    usedCount = 16'(int'(usedCount) - expCnt + refill);
    step();
    check("R9 popValid single", 64'(popValid), 64'd0);
    check("R10 busy low after completion", 64'(busy), 64'd0);
  endtask

  task automatic expectQuiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step();
      check({req, " stays idle"}, 64'(busy), 64'd0);
      check({req, " no dmaReq"}, 64'(dmaReq), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    bit clip;
    void'($urandom(32'd2718));
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1: reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 dmaReq", 64'(dmaReq), 64'd0);
    check("R1 popValid", 64'(popValid), 64'd0);
    check("R1 irqPost", 64'(irqPost), 64'd0);
    check("R1 headOut", 64'(headOut), 64'd0);

    // R2: plain burst, head 0 -> 5
    usedCount = 16'd5; wbMask = 16'd0; wbReq = 1'b1;
    runBurst(5, 0, 1'b0, 0, 0, 0, "R2");

    // R3: mask trims 13 to 12, head 5 -> 17
    usedCount = 16'd13; wbMask = 16'd3; wbReq = 1'b1;
    runBurst(12, 0, 1'b0, 0, 0, 0, "R3");

    // R5: 3 & ~7 = 0, nothing issued
    usedCount = 16'd3; wbMask = 16'd7; wbReq = 1'b1;
    step(); wbReq = 1'b0;
    check("R5 busy stays low", 64'(busy), 64'd0);
    expectQuiet(6, "R5");

    // R6: drain holds the issue for 4 extra cycles, head 17 -> 21
    usedCount = 16'd4; wbMask = 16'd0; wbReq = 1'b1;
    runBurst(4, 4, 1'b0, 0, 0, 0, "R6");

    // R8: 10 & ~7 = 8, smaller mask 1 merged; follow-on 2 & ~1 = 2
    usedCount = 16'd10; wbMask = 16'd7; wbReq = 1'b1;
    runBurst(8, 0, 1'b1, 15, 1, 0, "R8");
    runBurst(2, 0, 1'b0, 0, 0, 0, "R8 follow-on");

    // R4: head 31, one entry clips to 1; follow-on is empty
    usedCount = 16'd1; wbMask = 16'd0; wbReq = 1'b1;
    runBurst(1, 0, 1'b0, 0, 0, 0, "R4 clip");
    check("R4 head wrapped", 64'(headOut), 64'd0);
    expectQuiet(4, "R4");

    // R7: 7 & ~2 = 5, masks 2 and 3 not smaller -> ignored despite refill
    usedCount = 16'd7; wbMask = 16'd2; wbReq = 1'b1;
    runBurst(5, 0, 1'b1, 2, 3, 4, "R7");
    expectQuiet(8, "R7");

    // R4: head 5, 31 used clips to 27 unmasked; follow-on 4 & ~1 = 4
    usedCount = 16'd31; wbMask = 16'd1; wbReq = 1'b1;
    runBurst(27, 0, 1'b0, 0, 0, 0, "R4 unmasked clip");
    runBurst(4, 0, 1'b0, 0, 0, 0, "R4 follow-on");

    // R11: per-packet timer restarts; events at c0 and c3, delay 10
    usedCount = 16'd0; pktDelay = 16'd10; absDelay = 16'd0;
    pktEvt = 1'b1; step(); pktEvt = 1'b0; step(); step();
    pktEvt = 1'b1; step(); pktEvt = 1'b0;
    for (int i = 0; i < 9; i++) begin
      step();
      check("R11 no early irq", 64'(irqPost), 64'd0);
    end
    step();
    check("R11 irq after restart", 64'(irqPost), 64'd1);
    check("R11 empty forced writeback idle", 64'(busy), 64'd0);
    step();
    check("R11 irq single", 64'(irqPost), 64'd0);

    // R11: absolute timer ignores the second event; expiry forces mask 0
    pktDelay = 16'd0; absDelay = 16'd8; usedCount = 16'd5; wbMask = 16'd3; wbDelay = 8'd1;
    pktEvt = 1'b1; step(); pktEvt = 1'b0; step(); step();
    pktEvt = 1'b1; step(); pktEvt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R11 absolute not yet expired", 64'(busy), 64'd0);
    end
    runBurst(5, 0, 1'b0, 0, 0, 0, "R11 absolute");
    absDelay = 16'd0;

    // Random requests mixed with drain holds (R2, R3, R4, R5)
    for (int it = 0; it < 40; it++) begin
      int mask;
      int hold;
      bit first;
      mask = (1 << ($urandom % 4)) - 1;
      wbDelay = 8'($urandom % 4);
      usedCount = 16'($urandom % 40);
      wbMask = 16'(mask);
      first = 1'b1;
      do begin
        calcBurst(int'(usedCount), expHead, int'(ringLen), mask, cnt, clip);
        hold = int'($urandom % 3);
        if (first) wbReq = 1'b1;
        first = 1'b0;
        if (cnt == 0) begin
          step();
          wbReq = 1'b0;
          check("R5 random zero count", 64'(busy), 64'd0);
          clip = 1'b0;
        end else begin
          runBurst(cnt, hold, 1'b0, 0, 0, 0, clip ? "R4 random" : "R3 random");
        end
      end while (clip);
      expectQuiet(2, "R2 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule